// File: doc/BRIEF.md
# External Reset Pulse Generator

This block produces the reset pulse that a watchdog drives off-chip when its counter expires. A single 32-bit configuration register holds a pulse-length field in its low bits, plus two mode bits: the level the pin takes while asserted, and whether the pin is actively driven at both levels or only pulled to its asserted level with the enable released otherwise. The two mode bits are guarded. Each one changes only when the top byte of a write carries one of four key values. The length field takes the written data on every write.

A one-cycle `trigger` starts a pulse. The pulse waits for the next edge of the shared 1 µs tick strobe and then lasts exactly (field + 1) tick periods. The controller is a three-state machine:

- `ST_IDLE`: no pulse.
- `ST_ALIGN`: waiting for the first tick.
- `ST_DRIVE`: pin asserted, counting ticks.

It has three transitions:

- LAUNCH: `ST_IDLE` to `ST_ALIGN` on a trigger. The length field is captured at this point.
- START: `ST_ALIGN` to `ST_DRIVE` on a tick.
- EXPIRE: `ST_DRIVE` to `ST_IDLE` on a tick when the remaining count is zero.

While not in `ST_IDLE`, every trigger is ignored. A pin stage turns the asserted flag and the two mode bits into a pad value and a pad enable.

Top module: `ext_rst_pulser`

## Requirements
- R1: After reset the register reads 0x000000FF: bit 31 = 0 (active-low), bit 30 = 0 (open-drain), length field 0xFF, so an untouched block gives a 256-tick pulse.
- R2: Every write to offset 0x18 loads the length field, bits [FIELD_W-1:0], from the write data. Bits from FIELD_W to 29 always read 0.
- R3: A write whose bits [31:24] equal 0xA5 sets read bit 31 (asserted level high). A top byte of 0x5A clears it (asserted level low).
- R4: A write whose bits [31:24] equal 0xA8 sets read bit 30 (push-pull). A top byte of 0x8A clears it (open-drain).
- R5: A write with any other top byte leaves bits 31 and 30 unchanged.
- R6: A write at any offset other than 0x18 changes nothing, and a read at such an offset returns 0.
- R7: A trigger in `ST_IDLE` asserts the pin from the next tick for exactly (field + 1) tick periods. A field of 0 gives one tick period.
- R8: A trigger while a pulse is pending or being driven has no effect: neither the length of the pulse nor a second pulse.
- R9: The length is captured at the trigger. A write to the field during a pulse does not change that pulse's length.
- R10: In push-pull mode `pin_oe` is 1 at all times, and `pin_out` is the asserted level during the pulse and its inverse otherwise.
- R11: In open-drain mode `pin_oe` is 1 only during the pulse, and `pin_out` then holds the asserted level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| tick_1us | input | 1 | One-cycle 1 µs timing strobe |
| trigger | input | 1 | Start-of-pulse request |
| pin_out | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad output enable |

## Verification
The bench aims at three groups of fault.

- Key-value decoding. It writes near-miss top bytes (0xA7, 0x12, 0xFF, 0x00). A decoder that compared only some bits, or wrote the top byte straight into the mode bits, would flip a mode bit on these writes.
- Pulse length. It measures the pulse in clock cycles at field values 0, 2, 3, 5 and the reset value 255. An off-by-one counter, or one that started counting at the trigger instead of at the next tick, would give a length that is off by one tick or by part of one.
- Disturbances during a pulse. It fires a second trigger mid-pulse and rewrites the field mid-pulse. A machine that re-armed would stretch the pulse or emit a second one, and a counter that read the field live would cut the pulse short.

The pad is checked sample by sample in both drive modes, which catches an enable that stays on in open-drain mode and a value that does not invert in push-pull mode.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_DRIVE = 2'd2
    } pulse_state_t;

    localparam logic [7:0] KEY_LEVEL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_LEVEL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
    localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

    localparam int unsigned BIT_LEVEL = 31;
    localparam int unsigned BIT_DRIVE = 30;

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg
    import rpg_pkg::*;
#(
    parameter int unsigned FIELD_W     = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18,
    parameter logic [FIELD_W-1:0] FIELD_RST = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [FIELD_W-1:0] field,
    output logic               act_high,
    output logic               push_pull
);

    localparam int unsigned GAP_W = BIT_DRIVE - FIELD_W;

    logic       hit;
    logic [7:0] key;
    logic       key_hi, key_lo, key_pp, key_od;

    assign hit    = (addr == REG_OFS);
    assign key    = wdata[31:24];
    assign key_hi = (key == KEY_LEVEL_HIGH);
    assign key_lo = (key == KEY_LEVEL_LOW);
    assign key_pp = (key == KEY_PUSH_PULL);
    assign key_od = (key == KEY_OPEN_DRAIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field     <= FIELD_RST;
            act_high  <= 1'b0;
            push_pull <= 1'b0;
        end else if (wr_en && hit) begin
            field <= wdata[FIELD_W-1:0];
            if (key_hi)      act_high <= 1'b1;
            else if (key_lo) act_high <= 1'b0;
            if (key_pp)      push_pull <= 1'b1;
            else if (key_od) push_pull <= 1'b0;
        end
    end

    generate
        if (GAP_W > 0) begin : g_gap
            always_comb begin
                rdata = '0;
                if (hit) rdata = {act_high, push_pull, {GAP_W{1'b0}}, field};
            end
        end else begin : g_nogap
            always_comb begin
                rdata = '0;
                if (hit) rdata = {act_high, push_pull, field};
            end
        end
    endgenerate

    // R5: a non-key top byte must leave both mode bits alone
    p_keep_modes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !key_hi && !key_lo && !key_pp && !key_od)
        |=> ($stable(act_high) && $stable(push_pull)));

    // R2: the field takes the written data on each hit
    p_field_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit) |=> (field == $past(wdata[FIELD_W-1:0])));

    // R6: writes elsewhere leave the register untouched
    p_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> ($stable(field) && $stable(act_high) && $stable(push_pull)));

endmodule

// File: rtl/rpg_pulse_fsm.sv
module rpg_pulse_fsm
    import rpg_pkg::*;
#(
    parameter int unsigned FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               trigger,
    input  logic [FIELD_W-1:0] field,
    output logic               asserted
);

    pulse_state_t       state, state_nx;
    logic [FIELD_W-1:0] cnt;
    logic               last_tick;

    assign last_tick = tick && (cnt == '0);

    // next-state selection: LAUNCH, START, EXPIRE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (trigger)   state_nx = ST_ALIGN;
            ST_ALIGN: if (tick)      state_nx = ST_DRIVE;
            ST_DRIVE: if (last_tick) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // remaining tick count, captured on LAUNCH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == ST_IDLE && trigger) begin
            cnt <= field;
        end else if (state == ST_DRIVE && tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        asserted = 1'b0;
        unique case (state)
            ST_IDLE:  asserted = 1'b0;
            ST_ALIGN: asserted = 1'b0;
            ST_DRIVE: asserted = 1'b1;
            default:  asserted = 1'b0;
        endcase
    end

    // R8: a trigger outside IDLE leaves state and count as they were
    p_ignore_retrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && trigger && !tick) |=> ($stable(cnt) && $stable(state)));

    // R7: each tick inside the pulse removes exactly one from the count
    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRIVE && tick && cnt != '0) |=> (state == ST_DRIVE && cnt == $past(cnt) - 1'b1));

    // R7: the pin never asserts straight from IDLE
    p_no_skip_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_DRIVE));

endmodule

// File: rtl/rpg_pin_drv.sv
module rpg_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic asserted,
    input  logic act_high,
    input  logic push_pull,
    output logic pin_out,
    output logic pin_oe
);

    always_comb begin
        if (push_pull) begin
            pin_oe  = 1'b1;
            pin_out = asserted ? act_high : ~act_high;
        end else begin
            pin_oe  = asserted;
            pin_out = act_high;
        end
    end

    // R11: in open-drain mode the pad is released as the pulse ends
    p_od_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && $fell(asserted)) |-> !pin_oe);

    // R10: in push-pull mode the pad value moves only when pulse or level moves
    p_pp_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_pull && $stable(push_pull) && $stable(asserted) && $stable(act_high)) |-> $stable(pin_out));

endmodule

// File: rtl/ext_rst_pulser.sv
module ext_rst_pulser
    import rpg_pkg::*;
#(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              tick_1us,
    input  logic              trigger,
    output logic              pin_out,
    output logic              pin_oe
);

    localparam logic [FIELD_W-1:0] FIELD_RST = FIELD_W'(8'hFF);

    logic [FIELD_W-1:0] field;
    logic               act_high;
    logic               push_pull;
    logic               asserted;

    rpg_cfg_reg #(
        .FIELD_W   (FIELD_W),
        .ADDR_W    (ADDR_W),
        .REG_OFS   (REG_OFS),
        .FIELD_RST (FIELD_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .field     (field),
        .act_high  (act_high),
        .push_pull (push_pull)
    );

    rpg_pulse_fsm #(
        .FIELD_W (FIELD_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1us),
        .trigger  (trigger),
        .field    (field),
        .asserted (asserted)
    );

    rpg_pin_drv u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .asserted  (asserted),
        .act_high  (act_high),
        .push_pull (push_pull),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: tb/ext_rst_pulser_test.sv
module ext_rst_pulser_test;

    localparam int DIV = 4;
    localparam logic [7:0] OFS = 8'h18;
    localparam int NV = 8;
    localparam logic [31:0] VW [NV] = '{
        32'hA5000010, 32'hA8000003, 32'h12000007, 32'h5A0000FF,
        32'h8A000001, 32'hA7000020, 32'h00FFFF05, 32'hFF000000};
    localparam logic [31:0] VE [NV] = '{
        32'h80000010, 32'hC0000003, 32'hC0000007, 32'h400000FF,
        32'h00000001, 32'h00000020, 32'h00000005, 32'h00000000};
    localparam string VR [NV] = '{"R3", "R4", "R5", "R3", "R4", "R5", "R2", "R5"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = OFS;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_1us = 1'b0;
    logic        trigger = 1'b0;
    logic        pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_rst_pulser uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick_1us(tick_1us),
        .trigger(trigger), .pin_out(pin_out), .pin_oe(pin_oe));

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            tick_1us = (k == DIV - 1);
            k = (k == DIV - 1) ? 0 : k + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = OFS;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_addr = OFS;
    endtask

    // measures one pulse in clock cycles; lvl/pp describe the mode in force
    task automatic measure(input string req, input int ticks, input bit lvl, input bit pp,
                           input bit retrig, input bit wr_mid);
        int  n = 0;
        int  guard = 0;
        bit  seen = 0;
        bit  pad_bad = 0;
        bit  again = 0;
        bit  act;
        @(negedge clk);
        if (pp ? (pin_oe !== 1'b1 || pin_out !== ~lvl) : (pin_oe !== 1'b0))
            pad_bad = 1;
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        while (guard < 5000) begin
            guard++;
            act = pp ? (pin_out === lvl) : (pin_oe === 1'b1);
            if (pp && pin_oe !== 1'b1) pad_bad = 1;
            if (!pp && act && pin_out !== lvl) pad_bad = 1;
            if (act) begin
                seen = 1; n++;
            end else if (seen) begin
                break;
            end
            @(negedge clk);
            trigger = 1'b0; cfg_we = 1'b0; cfg_addr = OFS;
            if (n == 2) begin
                if (retrig) trigger = 1'b1;
                if (wr_mid) begin
                    cfg_we = 1'b1; cfg_wdata = 32'h00000001;
                end
            end
        end
        trigger = 1'b0; cfg_we = 1'b0;
        check({req, " pulse length"}, n, ticks * DIV);
        check({req, " pad levels"}, {31'b0, pad_bad}, 32'd0);
        for (int i = 0; i < 12 * DIV; i++) begin
            @(negedge clk);
            if (pp ? (pin_out === lvl) : (pin_oe === 1'b1)) again = 1;
        end
        check({req, " no second pulse (R8)"}, {31'b0, again}, 32'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(OFS, d);
        check("R1 reset value", d, 32'h000000FF);

        for (int i = 0; i < NV; i++) begin
            wr(OFS, VW[i]);
            rd(OFS, d);
            check({VR[i], " key decode"}, d, VE[i]);
        end

        // R6: write at another offset, read at another offset
        wr(8'h1C, 32'hA5A800FF);
        rd(OFS, d);
        check("R6 miss write", d, 32'h00000000);
        wr(OFS, 32'h00000077);
        rd(8'h1C, d);
        check("R6 miss read", d, 32'h00000000);

        // R7 R11: open-drain, active-low, field 3
        wr(OFS, 32'h00000003);
        measure("R7 R11 od low f3", 4, 1'b0, 1'b0, 1'b0, 1'b0);
        // R7: field 0 gives one tick
        wr(OFS, 32'h00000000);
        measure("R7 f0", 1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R10 R8: push-pull active-high, retrigger mid pulse
        wr(OFS, 32'hA5000002);
        wr(OFS, 32'hA8000002);
        measure("R10 R8 pp high retrig", 3, 1'b1, 1'b1, 1'b1, 1'b0);
        // R9: push-pull active-low, field rewritten mid pulse
        wr(OFS, 32'h5A000005);
        measure("R9 R10 pp low midwrite", 6, 1'b0, 1'b1, 1'b0, 1'b1);
        rd(OFS, d);
        check("R9 field after midwrite", d, 32'h40000001);
        // R11 R8: open-drain active-high, retrigger
        wr(OFS, 32'h8A000002);
        wr(OFS, 32'hA5000002);
        measure("R11 R8 od high retrig", 3, 1'b1, 1'b0, 1'b1, 1'b0);

        // R1: fresh reset gives the 256-tick open-drain active-low pulse
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(OFS, d);
        check("R1 reset value again", d, 32'h000000FF);
        measure("R1 R7 default pulse", 256, 1'b0, 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule